// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block runs single commands on a three-wire serial EEPROM (chip select, serial clock, data toward the memory, data from the memory) for a host that sees it as one control word. The control word packs a self-clearing busy flag, a 2-bit operation code and a 6-bit word address. Setting the busy flag starts a command. The block frames it with chip select and sends a start bit, the opcode and the address on a divided serial clock. Depending on the opcode it then sends 16 data bits from a host-held write word, or receives 16 bits into a read word. After a program or erase it polls the memory until the memory reports ready, and only then drops busy.

The host keeps writing the control word with busy cleared to stage fields. It writes the word with busy set to launch a command, then polls the busy flag. Control writes that arrive while a command is in flight are discarded. The write-enable and write-disable commands share opcode 00. The top two address bits select which one is sent, and the block passes them to the memory unchanged.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: After reset, ctrlRdData reads 0, and sCs, sClk, sOut and rdWord are all 0.
- R2: ctrlRdData reads busy at bit 8, the opcode at bits 7:6 and the address at bits 5:0, with bits 31:9 zero. A control write with bit 8 clear while idle stores the opcode and address and starts no frame.
- R3: A control write with bit 8 set while idle makes bit 8 read 1 from the next cycle and starts a frame. Bit 8 returns to 0 when the command completes, and opcode and address still read back as written.
- R4: A frame holds sCs high from its first bit to its last. The memory samples it on rising sClk edges as a start bit of 1, then the opcode in two bits, then the address in six bits, MSB first. sOut is 0 whenever sCs is low.
- R5: Opcode 10 (read) gives 26 serial clocks: the 9 header bits, one dummy bit with sOut 0, then 16 clocks in which sIn is sampled on each rising edge, MSB first, into rdWord.
- R6: Opcode 01 (write) gives 25 serial clocks: the 9 header bits followed by wrWord, MSB first.
- R7: Opcode 11 (erase) and opcode 00 give 9 serial clocks only. With opcode 00, address bits 5:4 equal to 11 send write-enable and 00 send write-disable, both sent as given.
- R8: After a write or an erase, sCs stays low for at least one serial clock period. It is then raised with sClk held low, and busy stays set until sIn is seen high, after which sCs drops and busy clears. Reads and opcode 00 commands complete without this polling phase.
- R9: The serial clock period is 2*SCLK_HALF system cycles, and sClk is low whenever sCs is low. sOut changes only when sClk falls or when sCs rises.
- R10: A control write while busy is set changes neither the stored opcode nor the address, and it does not disturb the command in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 9 | Control word write value: busy/start, opcode, address |
| ctrlRdData | output | 32 | Control word read value |
| wrWord | input | DATA_W | Data sent by a write command |
| rdWord | output | DATA_W | Data received by the last read command |
| sCs | output | 1 | Serial chip select, active high |
| sClk | output | 1 | Serial clock |
| sOut | output | 1 | Serial data toward the memory |
| sIn | input | 1 | Serial data and ready status from the memory |

## Verification
The bench builds the block with SCLK_HALF = 3, which gives an odd half-period and a six-cycle serial clock. Every bit-boundary and gap-length check therefore tells a correct divider apart from one that is off by one cycle, and frames stay short enough for many commands per run. ADDR_W and DATA_W keep their defaults of 6 and 16, so the frame lengths of 9, 25 and 26 clocks, the address extremes 0 and 63, and the enable/disable address patterns are all reachable. Poll delays from zero to several dozen cycles exercise both the immediate-ready case and long busy waits.

// File: rtl/eeprom_cmd_pkg.sv
package eeprom_cmd_pkg;

  typedef enum logic [1:0] {
    OP_WEN_WDS = 2'b00,
    OP_WRITE   = 2'b01,
    OP_READ    = 2'b10,
    OP_ERASE   = 2'b11
  } eeOp_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_GAP,
    ST_POLL
  } seqState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic capture;
  } dpCtl_t;

endpackage

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq
  import eeprom_cmd_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int SCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [ADDR_W+2:0] ctrlWrData,
  input  logic              sIn,
  output logic              busy,
  output eeOp_t             opReg,
  output logic [ADDR_W-1:0] addrReg,
  output logic              sCs,
  output logic              sClk,
  output dpCtl_t            dpCtl
);

  localparam int HDR_LEN  = 3 + ADDR_W;
  localparam int RD_LEN   = HDR_LEN + 1 + DATA_W;
  localparam int WR_LEN   = HDR_LEN + DATA_W;
  localparam int CNT_W    = $clog2(RD_LEN + 1);
  localparam int DIV_W    = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BUSY_BIT = ADDR_W + 2;

  seqState_t        state;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] frameLen;
  logic             gapHalf;
  logic             tick;
  logic             lastBit;
  logic             needPoll;

  assign tick     = (divCnt == DIV_W'(SCLK_HALF - 1));
  assign needPoll = (opReg == OP_WRITE) || (opReg == OP_ERASE);
  assign lastBit  = (bitCnt == frameLen - CNT_W'(1));

  always_comb begin
    case (opReg)
      OP_READ:  frameLen = CNT_W'(RD_LEN);
      OP_WRITE: frameLen = CNT_W'(WR_LEN);
      default:  frameLen = CNT_W'(HDR_LEN);
    endcase
  end

  always_comb begin
    dpCtl.load    = (state == ST_LOAD);
    dpCtl.shift   = (state == ST_SHIFT) && tick && sClk;
    dpCtl.capture = (state == ST_SHIFT) && tick && !sClk && (opReg == OP_READ)
                    && (bitCnt >= CNT_W'(HDR_LEN + 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      busy    <= 1'b0;
      opReg   <= OP_WEN_WDS;
      addrReg <= '0;
      sCs     <= 1'b0;
      sClk    <= 1'b0;
      divCnt  <= '0;
      bitCnt  <= '0;
      gapHalf <= 1'b0;
    end else begin
      if (ctrlWrEn && !busy) begin
        opReg   <= eeOp_t'(ctrlWrData[ADDR_W+1:ADDR_W]);
        addrReg <= ctrlWrData[ADDR_W-1:0];
        busy    <= ctrlWrData[BUSY_BIT];
        if (ctrlWrData[BUSY_BIT]) state <= ST_LOAD;
      end
      case (state)
        ST_LOAD: begin
          sCs    <= 1'b1;
          sClk   <= 1'b0;
          divCnt <= '0;
          bitCnt <= '0;
          state  <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (tick) begin
            divCnt <= '0;
            if (!sClk) begin
              sClk <= 1'b1;
            end else begin
              sClk <= 1'b0;
              if (lastBit) begin
                sCs     <= 1'b0;
                gapHalf <= 1'b0;
                state   <= ST_GAP;
              end else begin
                bitCnt <= bitCnt + CNT_W'(1);
              end
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_GAP: begin
          if (tick) begin
            divCnt <= '0;
            if (gapHalf) begin
              if (needPoll) begin
                sCs   <= 1'b1;
                state <= ST_POLL;
              end else begin
                busy  <= 1'b0;
                state <= ST_IDLE;
              end
            end else begin
              gapHalf <= 1'b1;
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_POLL: begin
          if (sIn) begin
            sCs   <= 1'b0;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  AST_IGNORE_BUSY_WR: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlWrEn) |=> ($stable(opReg) && $stable(addrReg))); // R10
  AST_CLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !sCs |-> !sClk); // R9
  AST_CS_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    sCs |-> busy); // R3
  AST_CLEAR_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && $past(state == ST_POLL)) |-> $past(sIn)); // R8

endmodule

// File: rtl/eeprom_cmd_dp.sv
module eeprom_cmd_dp
  import eeprom_cmd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  eeOp_t             opReg,
  input  logic [ADDR_W-1:0] addrReg,
  input  logic [DATA_W-1:0] wrWord,
  input  logic              sIn,
  output logic              sOut,
  output logic [DATA_W-1:0] rdWord
);

  localparam int SH_W = 3 + ADDR_W + DATA_W;

  logic [SH_W-1:0] shReg;

  assign sOut = shReg[SH_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      rdWord <= '0;
    end else begin
      if (dpCtl.load)
        shReg <= {1'b1, opReg, addrReg, (opReg == OP_WRITE) ? wrWord : {DATA_W{1'b0}}};
      else if (dpCtl.shift)
        shReg <= {shReg[SH_W-2:0], 1'b0};
      if (dpCtl.capture)
        rdWord <= {rdWord[DATA_W-2:0], sIn};
    end
  end

  AST_NO_LOAD_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    !(dpCtl.load && (dpCtl.shift || dpCtl.capture))); // R4

endmodule

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl
  import eeprom_cmd_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int SCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [ADDR_W+2:0] ctrlWrData,
  output logic [31:0]       ctrlRdData,
  input  logic [DATA_W-1:0] wrWord,
  output logic [DATA_W-1:0] rdWord,
  output logic              sCs,
  output logic              sClk,
  output logic              sOut,
  input  logic              sIn
);

  localparam int CW = ADDR_W + 3;

  logic              busy;
  eeOp_t             opReg;
  logic [ADDR_W-1:0] addrReg;
  dpCtl_t            dpCtl;

  eeprom_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SCLK_HALF(SCLK_HALF)) uSeq (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .sIn(sIn), .busy(busy), .opReg(opReg), .addrReg(addrReg),
    .sCs(sCs), .sClk(sClk), .dpCtl(dpCtl)
  );

  eeprom_cmd_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .opReg(opReg), .addrReg(addrReg),
    .wrWord(wrWord), .sIn(sIn), .sOut(sOut), .rdWord(rdWord)
  );

  assign ctrlRdData = {{(32-CW){1'b0}}, busy, opReg, addrReg};

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !sCs |-> !sOut); // R4
  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sOut) |-> ($fell(sClk) || $rose(sCs))); // R9

endmodule

// File: tb/tb_eeprom_cmd_ctrl.sv
module tb_eeprom_cmd_ctrl;

  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [8:0]  ctrlWrData = '0;
  logic [31:0] ctrlRdData;
  logic [15:0] wrWord = '0;
  logic [15:0] rdWord;
  logic        sCs, sClk, sOut;
  logic        sIn = 1'b0;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  eeprom_cmd_ctrl #(.ADDR_W(6), .DATA_W(16), .SCLK_HALF(HALF)) dut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData), .wrWord(wrWord), .rdWord(rdWord),
    .sCs(sCs), .sClk(sClk), .sOut(sOut), .sIn(sIn)
  );

  // memory model state
  int          mState = 0;
  int          cyc = 0;
  int          riseCnt = 0, lastRise = 0, gapStart = 0, pollCnt = 0, frameCnt = 0;
  logic [31:0] frameBits = '0;
  logic [1:0]  curOp = 2'b00;
  logic [15:0] readData = '0;
  int          pollDelay = 0;
  bit          prevSk = 0, pollSeen = 0, readySeen = 0, gapBad = 0, earlyClr = 0;
  int          periodErr = 0, idleClkErr = 0;

  always @(negedge clk) begin
    cyc++;
    case (mState)
      0: begin
        sIn = 1'b0;
        if (sClk) idleClkErr++;
        if (sCs) begin
          mState = 1; frameBits = '0; riseCnt = 0; frameCnt++;
        end
      end
      1: begin
        if (sClk && !prevSk) begin
          frameBits = {frameBits[30:0], sOut};
          riseCnt++;
          if (riseCnt > 1 && (cyc - lastRise) != 2 * HALF) periodErr++;
          lastRise = cyc;
        end
        if (!sClk && prevSk) begin
          if (curOp == 2'b10 && riseCnt >= 10 && riseCnt < 26)
            sIn = readData[25 - riseCnt];
          else
            sIn = 1'b0;
        end
        if (!sCs) begin
          sIn = 1'b0;
          gapStart = cyc;
          mState = (curOp == 2'b01 || curOp == 2'b11) ? 2 : 0;
        end
      end
      2: begin
        if (sClk) idleClkErr++;
        if (sCs) begin
          if ((cyc - gapStart) < 2 * HALF) gapBad = 1;
          pollSeen = 1; mState = 3; pollCnt = pollDelay;
        end
      end
      default: begin
        if (sClk) idleClkErr++;
        if (!sCs) begin
          mState = 0; sIn = 1'b0;
        end else if (pollCnt == 0) begin
          sIn = 1'b1; readySeen = 1;
        end else begin
          pollCnt--;
          if (!ctrlRdData[8]) earlyClr = 1;
        end
      end
    endcase
    prevSk = sClk;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int expLen(input logic [1:0] op);
    case (op)
      2'b10:   return 26;
      2'b01:   return 25;
      default: return 9;
    endcase
  endfunction

  function automatic logic [31:0] expFrame(input logic [1:0] op, input logic [5:0] addr,
                                           input logic [15:0] data);
    logic [8:0] hdr;
    hdr = {1'b1, op, addr};
    case (op)
      2'b10:   return {6'b0, hdr, 17'b0};
      2'b01:   return {7'b0, hdr, data};
      default: return {23'b0, hdr};
    endcase
  endfunction

  task automatic runCmd(input logic [1:0] op, input logic [5:0] addr, input logic [15:0] data,
                        input logic [15:0] rdVal, input int delay, input bit midWrite);
    int n;
    string tag;
    tag = (op == 2'b10) ? "R5" : (op == 2'b01) ? "R6" : "R7";
    curOp = op; readData = rdVal; pollDelay = delay;
    pollSeen = 0; readySeen = 0; gapBad = 0; earlyClr = 0; periodErr = 0; idleClkErr = 0;
    @(negedge clk);
    wrWord = data; ctrlWrData = {1'b1, op, addr}; ctrlWrEn = 1'b1;
    @(negedge clk);
    ctrlWrEn = 1'b0;
    check(ctrlRdData[8] == 1'b1, "R3 busy set", ctrlRdData, 32'h100);
    if (midWrite) begin
      repeat (7) @(negedge clk);
      ctrlWrData = 9'($urandom); ctrlWrEn = 1'b1;
      @(negedge clk);
      ctrlWrEn = 1'b0;
      check(ctrlRdData[8:0] == {1'b1, op, addr}, "R10 busy write ignored",
            ctrlRdData, {23'b0, 1'b1, op, addr});
    end
    n = 5000;
    while (ctrlRdData[8] && n > 0) begin
      @(negedge clk);
      n--;
    end
    check(n > 0, "R3 busy clears", ctrlRdData, 0);
    check(ctrlRdData == {23'b0, 1'b0, op, addr}, "R3 readback", ctrlRdData,
          {23'b0, 1'b0, op, addr});
    check(riseCnt == expLen(op), {tag, " clock count"}, riseCnt, expLen(op));
    check((frameBits & ((32'h1 << expLen(op)) - 1)) == expFrame(op, addr, data),
          {"R4 ", tag, " frame bits"}, frameBits, expFrame(op, addr, data));
    if (op == 2'b10)
      check(rdWord == rdVal, "R5 read data", rdWord, rdVal);
    if (op == 2'b01 || op == 2'b11)
      check(pollSeen && readySeen && !gapBad && !earlyClr, "R8 poll after program",
            {gapBad, earlyClr, readySeen, pollSeen}, 32'h3);
    else
      check(!pollSeen, "R8 no poll", pollSeen, 0);
    check(periodErr == 0 && idleClkErr == 0, "R9 serial clock", periodErr, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4417));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(ctrlRdData == 0, "R1 ctrl reset", ctrlRdData, 0);
    check({sCs, sClk, sOut} == 3'b000, "R1 serial reset", {sCs, sClk, sOut}, 0);
    check(rdWord == 0, "R1 rdWord reset", rdWord, 0);

    // R2: staging write without start
    begin
      int f0;
      f0 = frameCnt;
      ctrlWrData = {1'b0, 2'b10, 6'h2A}; ctrlWrEn = 1'b1;
      @(negedge clk);
      ctrlWrEn = 1'b0;
      check(ctrlRdData == 32'h0AA, "R2 field layout", ctrlRdData, 32'h0AA);
      repeat (20) @(negedge clk);
      check(frameCnt == f0 && !sCs, "R2 no frame", frameCnt, f0);
    end

    // directed corners
    runCmd(2'b00, 6'h30, 16'h0, 16'h0, 0, 0);        // enable
    runCmd(2'b00, 6'h00, 16'h0, 16'h0, 0, 0);        // disable
    runCmd(2'b01, 6'h3F, 16'hFFFF, 16'h0, 0, 0);
    runCmd(2'b01, 6'h00, 16'h0000, 16'h0, 40, 1);
    runCmd(2'b10, 6'h3F, 16'h0, 16'hFFFF, 0, 0);
    runCmd(2'b10, 6'h00, 16'h0, 16'h8001, 0, 1);
    runCmd(2'b11, 6'h15, 16'h0, 16'h0, 0, 0);
    runCmd(2'b11, 6'h2A, 16'h0, 16'h0, 55, 1);

    // constrained random
    for (int i = 0; i < 40; i++) begin
      logic [1:0] op;
      logic [5:0] ad;
      op = 2'($urandom);
      ad = 6'($urandom);
      if (op == 2'b00) ad[5:4] = ($urandom % 2) ? 2'b11 : 2'b00;
      runCmd(op, ad, 16'($urandom), 16'($urandom), int'($urandom % 30), bit'($urandom % 2));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  int wdog = 0;
  always @(posedge clk) begin
    wdog++;
    if (wdog == 150000 && !finished) begin
      finished = 1;
      testCnt++;
      failCnt++;
      $display("FAIL watchdog R3 actual=%0d expected=0", wdog);
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule